// File: doc/BRIEF.md
# Token-Scanned Micro-Ring Heater Array Driver

This block drives the on/off enables of a large array of micro-ring heaters from a handful of control pins. A one-hot token, kept in a circular register, selects the group of rings that is being written. A single serial line carries the per-ring bits, and a shift strobe clocks each bit in. A latch strobe then commits the shifted word to the group that the token reaches and moves the token on. In the default arrangement of 16 groups of 28 rings, 448 enables are controlled from five control inputs.

Each group keeps its own stored row. A latch with no shift since the previous latch reuses the row already held for the group the token reaches. A full pattern can therefore be written once, then scanned again and again by latch strobes alone. An active-low setup input clears the token, the shifter and every stored row. While it is low, the enable-type input is sampled, and the value present when setup goes high decides how the stored rows reach the outputs. In scan type only the group holding the token is powered. In persist type every group drives its stored row.

The control logic is a three-state machine. ST_CLEAR is entered on setup low and held while setup stays low. ST_CLEAR goes to ST_ARMED when setup is high, capturing the enable type. ST_ARMED goes to ST_SCAN on the first latch, which places the token at group 0. ST_SCAN stays in ST_SCAN on each further latch, which advances the token. Any state returns to ST_CLEAR when setup goes low.

Top module: `heater_scan_top`

## Requirements
- R1: After reset, and on the clock edge after setup_n_i is sampled low, every bit of heat_en_o and grp_token_o is 0.
- R2: Ring r of group g drives heat_en_o[g*28 + r]. Serial bits enter most significant first, so after 28 shifts the first bit shifted sits at ring 27 and the last bit at ring 0.
- R3: grp_token_o has at most one bit set. The first latch after setup release sets bit 0. Each later latch moves the token to the next group, and a latch at group 15 moves it back to group 0.
- R4: In scan type (mode_sel_i = 0 at release), heat_en_o is the stored row of the token group at that group's positions and 0 everywhere else.
- R5: In persist type (mode_sel_i = 1 at release), every group drives its stored row at the same time, whether or not it holds the token.
- R6: A latch with at least one shift since the previous latch (or since release) stores the shifter contents into the group the token moves to. A latch with no shift in between leaves that group's stored row unchanged and drives it again.
- R7: heat_en_o changes only on a clock edge where the latch strobe is accepted or setup_n_i is low. Shifting alone leaves it unchanged.
- R8: mode_sel_i is taken only on the release of setup_n_i. Changes to it while setup is high have no effect on the outputs.
- R9: Taking setup_n_i low in the middle of a scan clears the stored rows. Latches after the next release, with no new shifts, give all-zero enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial ring data bit |
| shift_stb_i | input | 1 | Shift strobe: clocks ser_data_i into the shifter |
| latch_stb_i | input | 1 | Latch strobe: commits a row and moves the token |
| mode_sel_i | input | 1 | Enable type: 0 scan, 1 persist |
| setup_n_i | input | 1 | Active-low setup: clears the array and times mode capture |
| heat_en_o | output | 448 | Heater enables, ring r of group g at bit g*28+r |
| grp_token_o | output | 16 | One-hot group token |

## Verification
The properties assume that the strobes are synchronous one-cycle levels sampled on the block clock. They also assume that mode_sel_i matters only at the release of setup, and that latches issued before the machine has left ST_CLEAR are not counted. The stimulus drives every strobe on the falling edge for exactly one period and waits two cycles after each release before the first latch. It also toggles mode_sel_i during a scan only to show that the change is ignored. Shift and latch strobes are never raised in the same cycle, so the order between the two in that case is not exercised.

// File: rtl/heater_scan_pkg.sv
package heater_scan_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ARMED = 2'd1,
        ST_SCAN  = 2'd2
    } scan_state_e;

    typedef enum logic {
        EN_SCAN    = 1'b0,
        EN_PERSIST = 1'b1
    } en_mode_e;

endpackage

// File: rtl/heater_token_fsm.sv
module heater_token_fsm
    import heater_scan_pkg::*;
#(
    parameter int GROUPS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       setup_n_i,
    input  logic                       latch_stb_i,
    input  logic                       mode_sel_i,
    output scan_state_e                state_q,
    output en_mode_e                   mode_q,
    output logic                       commit_o,
    output logic [GROUPS-1:0]          token_q,
    output logic [GROUPS-1:0]          token_d,
    output logic [$clog2(GROUPS)-1:0]  idx_d
);

    localparam int GW = $clog2(GROUPS);
    localparam logic [GW-1:0] LAST_IDX = GW'(GROUPS - 1);

    scan_state_e      state_d;
    logic [GW-1:0]    idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
            token_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            token_q <= token_d;
        end
    end

    // enable type captured on setup release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= EN_SCAN;
        end else if (state_q == ST_CLEAR && setup_n_i) begin
            mode_q <= en_mode_e'(mode_sel_i);
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        commit_o = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                if (setup_n_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (latch_stb_i) begin
                    commit_o = 1'b1;
                    state_d  = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (latch_stb_i) commit_o = 1'b1;
            end
            default: state_d = ST_CLEAR;
        endcase
        if (!setup_n_i) begin
            state_d  = ST_CLEAR;
            commit_o = 1'b0;
        end
    end

    always_comb begin
        idx_d   = idx_q;
        token_d = token_q;
        if (!setup_n_i) begin
            idx_d   = '0;
            token_d = '0;
        end else if (commit_o) begin
            if (state_q == ST_ARMED) begin
                idx_d   = '0;
                token_d = GROUPS'(1);
            end else begin
                idx_d   = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                token_d = {token_q[GROUPS-2:0], token_q[GROUPS-1]};
            end
        end
    end

endmodule

// File: rtl/heater_serial_in.sv
module heater_serial_in #(
    parameter int RINGS = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_n_i,
    input  logic             ser_data_i,
    input  logic             shift_stb_i,
    input  logic             commit_i,
    output logic [RINGS-1:0] word_q,
    output logic             fresh_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            fresh_q <= 1'b0;
        end else if (!setup_n_i) begin
            word_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            if (shift_stb_i) begin
                word_q <= {word_q[RINGS-2:0], ser_data_i};
            end
            if (shift_stb_i) begin
                fresh_q <= 1'b1;
            end else if (commit_i) begin
                fresh_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/heater_row_store.sv
module heater_row_store #(
    parameter int GROUPS = 16,
    parameter int RINGS  = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       setup_n_i,
    input  logic                       commit_i,
    input  logic                       fresh_i,
    input  logic [$clog2(GROUPS)-1:0]  idx_d,
    input  logic [RINGS-1:0]           word_i,
    output logic [GROUPS*RINGS-1:0]    rows_d
);

    localparam int GW = $clog2(GROUPS);

    logic [GROUPS*RINGS-1:0] rows_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_row
        always_comb begin
            rows_d[g*RINGS +: RINGS] = rows_q[g*RINGS +: RINGS];
            if (!setup_n_i) begin
                rows_d[g*RINGS +: RINGS] = '0;
            end else if (commit_i && fresh_i && idx_d == GW'(g)) begin
                rows_d[g*RINGS +: RINGS] = word_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q <= '0;
        end else begin
            rows_q <= rows_d;
        end
    end

endmodule

// File: rtl/heater_scan_top.sv
module heater_scan_top
    import heater_scan_pkg::*;
#(
    parameter int GROUPS = 16,
    parameter int RINGS  = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_data_i,
    input  logic                     shift_stb_i,
    input  logic                     latch_stb_i,
    input  logic                     mode_sel_i,
    input  logic                     setup_n_i,
    output logic [GROUPS*RINGS-1:0]  heat_en_o,
    output logic [GROUPS-1:0]        grp_token_o
);

    localparam int GW    = $clog2(GROUPS);
    localparam int TOTAL = GROUPS * RINGS;

    scan_state_e        state_q;
    en_mode_e           mode_q;
    logic               commit;
    logic [GROUPS-1:0]  token_d;
    logic [GW-1:0]      idx_d;
    logic [RINGS-1:0]   word;
    logic               fresh;
    logic [TOTAL-1:0]   rows_d;
    logic [TOTAL-1:0]   heat_d;

    heater_token_fsm #(.GROUPS(GROUPS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_n_i   (setup_n_i),
        .latch_stb_i (latch_stb_i),
        .mode_sel_i  (mode_sel_i),
        .state_q     (state_q),
        .mode_q      (mode_q),
        .commit_o    (commit),
        .token_q     (grp_token_o),
        .token_d     (token_d),
        .idx_d       (idx_d)
    );

    heater_serial_in #(.RINGS(RINGS)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_n_i   (setup_n_i),
        .ser_data_i  (ser_data_i),
        .shift_stb_i (shift_stb_i),
        .commit_i    (commit),
        .word_q      (word),
        .fresh_q     (fresh)
    );

    heater_row_store #(.GROUPS(GROUPS), .RINGS(RINGS)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_n_i (setup_n_i),
        .commit_i  (commit),
        .fresh_i   (fresh),
        .idx_d     (idx_d),
        .word_i    (word),
        .rows_d    (rows_d)
    );

    // gate each group's row by its token or by persist type
    for (genvar g = 0; g < GROUPS; g++) begin : g_gate
        assign heat_d[g*RINGS +: RINGS] =
            rows_d[g*RINGS +: RINGS] & {RINGS{(mode_q == EN_PERSIST) | token_d[g]}};
    end

    // output register: moves only on a commit or a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            heat_en_o <= '0;
        end else if (!setup_n_i) begin
            heat_en_o <= '0;
        end else if (commit) begin
            heat_en_o <= heat_d;
        end
    end

endmodule

// File: rtl/heater_scan_chk.sv
module heater_scan_chk
    import heater_scan_pkg::*;
#(
    parameter int GROUPS = 16,
    parameter int RINGS  = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     setup_n_i,
    input  logic                     latch_stb_i,
    input  logic [GROUPS*RINGS-1:0]  heat_en_o,
    input  logic [GROUPS-1:0]        grp_token_o,
    input  scan_state_e              state_q,
    input  en_mode_e                 mode_q
);

    logic [GROUPS*RINGS-1:0] tok_mask;
    for (genvar g = 0; g < GROUPS; g++) begin : g_mask
        assign tok_mask[g*RINGS +: RINGS] = {RINGS{grp_token_o[g]}};
    end

    // R3: token never has more than one bit
    assert_token_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_token_o));

    // R1: setup low clears outputs on the next edge
    assert_setup_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_n_i |=> (heat_en_o == '0 && grp_token_o == '0));

    // R7: without an accepted latch or a clear the enables hold
    assert_hold_between_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_n_i && !latch_stb_i) |=> $stable(heat_en_o));

    // R3: each latch in scan moves the token by one group, wrapping
    assert_token_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && setup_n_i && latch_stb_i) |=>
        (grp_token_o == {$past(grp_token_o[GROUPS-2:0]), $past(grp_token_o[GROUPS-1])}));

    // R4: in scan type no enable lies outside the token group
    assert_scan_confine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == EN_SCAN) |-> ((heat_en_o & ~tok_mask) == '0));

    // R8: enable type frozen once out of the clear state
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CLEAR && setup_n_i) |=> $stable(mode_q));

endmodule

bind heater_scan_top heater_scan_chk #(.GROUPS(GROUPS), .RINGS(RINGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_n_i   (setup_n_i),
    .latch_stb_i (latch_stb_i),
    .heat_en_o   (heat_en_o),
    .grp_token_o (grp_token_o),
    .state_q     (state_q),
    .mode_q      (mode_q)
);

// File: tb/tb_heater_scan_top.sv
module tb_heater_scan_top;

    localparam int G = 16;
    localparam int R = 28;
    localparam int T = G * R;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_data_i = 1'b0;
    logic          shift_stb_i = 1'b0;
    logic          latch_stb_i = 1'b0;
    logic          mode_sel_i = 1'b0;
    logic          setup_n_i = 1'b1;
    logic [T-1:0]  heat_en_o;
    logic [G-1:0]  grp_token_o;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic [R-1:0]  m_rows [G];
    logic [R-1:0]  m_sr;
    logic          m_fresh;
    int            m_idx;
    int            m_state;   // 0 clear, 1 armed, 2 scan
    logic          m_mode;

    always #5 clk = ~clk;

    heater_scan_top #(.GROUPS(G), .RINGS(R)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_data_i  (ser_data_i),
        .shift_stb_i (shift_stb_i),
        .latch_stb_i (latch_stb_i),
        .mode_sel_i  (mode_sel_i),
        .setup_n_i   (setup_n_i),
        .heat_en_o   (heat_en_o),
        .grp_token_o (grp_token_o)
    );

    function automatic logic [R-1:0] pat(int g, int p);
        logic [31:0] v;
        v = (32'(g) * 32'h0493_E5A1) ^ (32'(p + 1) * 32'h00A3_7C5D) ^ (32'h5A5A_5A5A >> g);
        return v[R-1:0];
    endfunction

    function automatic logic [T-1:0] exp_heat();
        logic [T-1:0] v;
        v = '0;
        if (m_state == 2) begin
            for (int g = 0; g < G; g++) begin
                if (m_mode || g == m_idx) v[g*R +: R] = m_rows[g];
            end
        end
        return v;
    endfunction

    function automatic logic [G-1:0] exp_tok();
        return (m_state == 2) ? (G'(1) << m_idx) : '0;
    endfunction

    task automatic check(string req);
        n_vec++;
        if (heat_en_o !== exp_heat()) begin
            n_bad++;
            $display("FAIL %s heat_en_o act=%h exp=%h", req, heat_en_o, exp_heat());
        end
        n_vec++;
        if (grp_token_o !== exp_tok()) begin
            n_bad++;
            $display("FAIL %s grp_token_o act=%h exp=%h", req, grp_token_o, exp_tok());
        end
    endtask

    task automatic shift_bits(logic [R-1:0] w, int hi, int lo);
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk);
            shift_stb_i = 1'b1;
            ser_data_i  = w[i];
            m_sr        = {m_sr[R-2:0], w[i]};
            m_fresh     = 1'b1;
        end
        @(negedge clk);
        shift_stb_i = 1'b0;
        ser_data_i  = 1'b0;
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        latch_stb_i = 1'b1;
        if (m_state != 0) begin
            m_idx = (m_state == 1) ? 0 : (m_idx + 1) % G;
            if (m_fresh) m_rows[m_idx] = m_sr;
            m_fresh = 1'b0;
            m_state = 2;
        end
        @(negedge clk);
        latch_stb_i = 1'b0;
    endtask

    task automatic setup_cycle(logic md, string req);
        @(negedge clk);
        setup_n_i  = 1'b0;
        mode_sel_i = md;
        for (int g = 0; g < G; g++) m_rows[g] = '0;
        m_sr = '0; m_fresh = 1'b0; m_state = 0; m_idx = 0;
        @(negedge clk);
        check(req);
        @(negedge clk);
        setup_n_i = 1'b1;
        m_mode    = md;
        m_state   = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int g = 0; g < G; g++) m_rows[g] = '0;
        m_sr = '0; m_fresh = 1'b0; m_idx = 0; m_state = 0; m_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        m_state = 1;
        @(negedge clk);

        // scan type, first pass with fresh words
        setup_cycle(1'b0, "R1 setup");
        for (int g = 0; g < G; g++) begin
            logic [R-1:0] w;
            w = (g == 0) ? (R'(1) << (R - 1)) : pat(g, 0);
            if (g == 3) begin
                shift_bits(w, R - 1, R / 2);
                check("R7 mid-shift");
                shift_bits(w, R / 2 - 1, 0);
                check("R7 after shift");
            end else begin
                shift_bits(w, R - 1, 0);
            end
            latch_pulse();
            check("R4 R6 scan write");
            if (g == 0) begin
                n_vec++;
                if (heat_en_o[R-1] !== 1'b1 || heat_en_o[R-2:0] !== '0) begin
                    n_bad++;
                    $display("FAIL R2 msb-first act=%h exp=%h", heat_en_o[R-1:0], R'(1) << (R - 1));
                end
            end
        end

        // second pass, no shifts: reuse stored rows and wrap
        for (int g = 0; g < G; g++) begin
            if (g == 5) mode_sel_i = 1'b1;  // R8: ignored while setup high
            latch_pulse();
            check("R3 R6 R8 rescan");
        end
        mode_sel_i = 1'b0;

        // persist type
        setup_cycle(1'b1, "R1 setup persist");
        for (int g = 0; g < G; g++) begin
            shift_bits(pat(g, 1), R - 1, 0);
            latch_pulse();
            check("R5 persist write");
        end
        for (int g = 0; g < G; g++) begin
            if (g % 3 == 0) shift_bits(pat(g, 2), R - 1, 0);
            latch_pulse();
            check("R5 R6 partial rewrite");
        end

        // all-ones and all-zeros edges in scan type, then mid-scan clear
        setup_cycle(1'b0, "R1 setup edge");
        shift_bits('1, R - 1, 0);
        latch_pulse();
        check("R4 all ones");
        shift_bits('0, R - 1, 0);
        latch_pulse();
        check("R4 all zeros");
        latch_pulse();
        check("R3 step");
        setup_cycle(1'b0, "R9 clear mid-scan");
        for (int g = 0; g < 3; g++) begin
            latch_pulse();
            check("R9 rows cleared");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule